// File: doc/BRIEF.md
# Load Result Formatter

This block sits between the data returned by a memory read and the register file write port. It takes a raw 64-bit memory word and an access size of 1, 2, 4 or 8 bytes. It also takes a formatting mode, which is zero-extend, sign-extend or byte-reverse. From these it produces the 64-bit value to be written to the target register. The raw data arrives right-aligned, so an access of N bytes occupies the least significant 8*N bits of the input word. Bytes are read in big-endian order: the most significant byte of the field is the first byte in memory.

The block is purely combinational. Not every size and mode pairing is meaningful. Sign extension exists only for halfword and word sizes, and byte reversal is undefined for a single byte. For a pairing that is not defined, the block raises an unsupported flag and drives a zero result. When the valid strobe is low, the result and the flag are both held at zero.

Top module: `ldfmt_top`

## Requirements
- R1: With valid high and mode 2'b00 (zero-extend), the result holds the low 8*N bits of the raw word, and every bit above them is zero. N is the access size: size code 2'b00=1, 2'b01=2, 2'b10=4, 2'b11=8 bytes. For size code 2'b11 the raw word passes through unchanged.
- R2: With valid high and mode 2'b01 (sign-extend) at size code 2'b01 or 2'b10, the result holds the low field, and every upper bit is a copy of the field's top bit.
- R3: With valid high, mode 2'b10 (byte-reverse) and size code 2'b01, result[15:8] equals raw[7:0] and result[7:0] equals raw[15:8]. Bits 63:16 are zero.
- R4: With valid high, mode 2'b10 and size code 2'b10, the four low bytes of the raw word appear in reverse order in result[31:0]. Bits 63:32 are zero.
- R5: With valid high, mode 2'b10 and size code 2'b11, all eight bytes appear in reverse order: result byte i equals raw byte 7-i.
- R6: With valid high, the following pairings raise unsup_o and force the result to zero: sign-extend with size code 2'b00 or 2'b11, byte-reverse with size code 2'b00, and mode 2'b11 with any size.
- R7: With valid low, result_o is zero and unsup_o is low, whatever the other inputs are.
- R8: With valid high and a supported pairing, unsup_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| valid_i | input | 1 | Qualifies the current raw word |
| size_i | input | 2 | Access size code (1, 2, 4, 8 bytes) |
| mode_i | input | 2 | Formatting mode: zero, sign, reverse, reserved |
| raw_i | input | 64 | Right-aligned raw memory data |
| result_o | output | 64 | Formatted register value |
| unsup_o | output | 1 | Size/mode pairing is not defined |

## Verification
The bench builds the block with its default parameters: 8-bit bytes and four size codes. This gives a 64-bit datapath, so every size from a single byte up to a full doubleword can be reached. Each of the twelve legal and illegal size/mode pairings is driven with several data patterns, including patterns whose field sign bit is set and patterns whose field sign bit is clear. A software model predicts the result for each one. The reserved mode and the idle strobe are also covered.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;

    // Formatting mode selector.
    typedef enum logic [1:0] {
        MD_ZERO = 2'd0,
        MD_SIGN = 2'd1,
        MD_REV  = 2'd2,
        MD_RSVD = 2'd3
    } ld_mode_e;

    localparam int unsigned LD_BYTE_W = 8;
    localparam int unsigned LD_NSIZE  = 4;

endpackage

// File: rtl/ldfmt_extend.sv
// Zero- and sign-extended views of the right-aligned field, one per size code.
module ldfmt_extend #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned NSIZE  = 4,
    localparam int unsigned DATA_W = BYTE_W << (NSIZE - 1)
) (
    input  logic [DATA_W-1:0]             raw_i,
    output logic [NSIZE-1:0][DATA_W-1:0]  zext_o,
    output logic [NSIZE-1:0][DATA_W-1:0]  sext_o
);

    for (genvar k = 0; k < NSIZE; k++) begin : g_size
        localparam int unsigned FW = BYTE_W << k;
        if (FW == DATA_W) begin : g_full
            assign zext_o[k] = raw_i;
            assign sext_o[k] = raw_i;
        end else begin : g_part
            assign zext_o[k] = {{(DATA_W - FW){1'b0}}, raw_i[FW-1:0]};
            assign sext_o[k] = {{(DATA_W - FW){raw_i[FW-1]}}, raw_i[FW-1:0]};
        end
    end

endmodule

// File: rtl/ldfmt_byterev.sv
// Byte-reversed views of the right-aligned field, one per size code.
module ldfmt_byterev #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned NSIZE  = 4,
    localparam int unsigned DATA_W = BYTE_W << (NSIZE - 1)
) (
    input  logic [DATA_W-1:0]             raw_i,
    output logic [NSIZE-1:0][DATA_W-1:0]  rev_o
);

    for (genvar k = 0; k < NSIZE; k++) begin : g_size
        localparam int unsigned NB = 1 << k;
        localparam int unsigned FW = BYTE_W * NB;
        for (genvar b = 0; b < NB; b++) begin : g_byte
            assign rev_o[k][b*BYTE_W +: BYTE_W] = raw_i[(NB-1-b)*BYTE_W +: BYTE_W];
        end
        if (FW < DATA_W) begin : g_pad
            assign rev_o[k][DATA_W-1:FW] = '0;
        end
    end

endmodule

// File: rtl/ldfmt_legal.sv
// Decides whether a size/mode pairing is defined.
module ldfmt_legal #(
    parameter int unsigned NSIZE = 4,
    localparam int unsigned SZ_W = $clog2(NSIZE)
) (
    input  logic [SZ_W-1:0]        size_i,
    input  ldfmt_pkg::ld_mode_e    mode_i,
    output logic                   ok_o
);
    import ldfmt_pkg::*;

    localparam logic [SZ_W-1:0] SZ_MIN = '0;
    localparam logic [SZ_W-1:0] SZ_MAX = SZ_W'(NSIZE - 1);

    always_comb begin
        unique case (mode_i)
            MD_ZERO: ok_o = 1'b1;
            MD_SIGN: ok_o = (size_i != SZ_MIN) && (size_i != SZ_MAX);
            MD_REV:  ok_o = (size_i != SZ_MIN);
            default: ok_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/ldfmt_top.sv
module ldfmt_top #(
    parameter int unsigned BYTE_W = ldfmt_pkg::LD_BYTE_W,
    parameter int unsigned NSIZE  = ldfmt_pkg::LD_NSIZE,
    localparam int unsigned DATA_W = BYTE_W << (NSIZE - 1),
    localparam int unsigned SZ_W   = $clog2(NSIZE)
) (
    input  logic              valid_i,
    input  logic [SZ_W-1:0]   size_i,
    input  logic [1:0]        mode_i,
    input  logic [DATA_W-1:0] raw_i,
    output logic [DATA_W-1:0] result_o,
    output logic              unsup_o
);
    import ldfmt_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              unsup;
    } fmt_res_t;

    ld_mode_e                    mode_d;
    logic [NSIZE-1:0][DATA_W-1:0] zext_d;
    logic [NSIZE-1:0][DATA_W-1:0] sext_d;
    logic [NSIZE-1:0][DATA_W-1:0] rev_d;
    logic                         ok_d;
    fmt_res_t                     res_d;

    assign mode_d = ld_mode_e'(mode_i);

    ldfmt_extend #(.BYTE_W(BYTE_W), .NSIZE(NSIZE)) ext_i (
        .raw_i  (raw_i),
        .zext_o (zext_d),
        .sext_o (sext_d)
    );

    ldfmt_byterev #(.BYTE_W(BYTE_W), .NSIZE(NSIZE)) rev_i (
        .raw_i (raw_i),
        .rev_o (rev_d)
    );

    ldfmt_legal #(.NSIZE(NSIZE)) legal_i (
        .size_i (size_i),
        .mode_i (mode_d),
        .ok_o   (ok_d)
    );

    always_comb begin
        res_d = '0;
        if (valid_i) begin
            if (!ok_d) begin
                res_d.unsup = 1'b1;
            end else begin
                unique case (mode_d)
                    MD_SIGN: res_d.data = sext_d[size_i];
                    MD_REV:  res_d.data = rev_d[size_i];
                    default: res_d.data = zext_d[size_i];
                endcase
            end
        end
    end

    assign result_o = res_d.data;
    assign unsup_o  = res_d.unsup;

endmodule

// File: rtl/ldfmt_chk.sv
module ldfmt_chk #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned NSIZE  = 4,
    localparam int unsigned DATA_W = BYTE_W << (NSIZE - 1),
    localparam int unsigned SZ_W   = $clog2(NSIZE)
) (
    input logic              valid_i,
    input logic [SZ_W-1:0]   size_i,
    input logic [1:0]        mode_i,
    input logic [DATA_W-1:0] raw_i,
    input logic [DATA_W-1:0] result_o,
    input logic              unsup_o
);
    localparam logic [SZ_W-1:0] SZ_MAX = SZ_W'(NSIZE - 1);

    int unsigned fw;
    assign fw = BYTE_W << size_i;

    always_comb begin
        if (valid_i === 1'b0) begin
            AST_IDLE_QUIET: assert (result_o == '0 && !unsup_o); // R7
        end
        if (unsup_o === 1'b1) begin
            AST_UNSUP_ZERO: assert (result_o == '0 && valid_i); // R6
        end
        if (valid_i === 1'b1 && mode_i == 2'd0 && size_i != SZ_MAX) begin
            AST_ZEXT_UPPER: assert ((result_o >> fw) == '0); // R1
        end
        if (valid_i === 1'b1 && mode_i == 2'd2 && size_i != SZ_MAX && size_i != '0) begin
            AST_REV_UPPER: assert ((result_o >> fw) == '0); // R4
        end
        if (valid_i === 1'b1 && mode_i == 2'd1 && size_i != SZ_MAX && size_i != '0) begin
            AST_SIGN_UPPER: assert (result_o[DATA_W-1] == raw_i[fw-1]); // R2
        end
        if (valid_i === 1'b1 && mode_i == 2'd0) begin
            AST_ZERO_SUPPORTED: assert (!unsup_o); // R8
        end
    end

endmodule

bind ldfmt_top ldfmt_chk #(.BYTE_W(BYTE_W), .NSIZE(NSIZE)) chk_i (
    .valid_i  (valid_i),
    .size_i   (size_i),
    .mode_i   (mode_i),
    .raw_i    (raw_i),
    .result_o (result_o),
    .unsup_o  (unsup_o)
);

// File: tb/ldfmt_top_tb_top.sv
module ldfmt_top_tb_top;

    logic        clk = 1'b0;
    logic        valid_i;
    logic [1:0]  size_i;
    logic [1:0]  mode_i;
    logic [63:0] raw_i;
    logic [63:0] result_o;
    logic        unsup_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    ldfmt_top dut_i (
        .valid_i  (valid_i),
        .size_i   (size_i),
        .mode_i   (mode_i),
        .raw_i    (raw_i),
        .result_o (result_o),
        .unsup_o  (unsup_o)
    );

    function automatic logic [64:0] model(input logic v, input logic [1:0] sz,
                                          input logic [1:0] md, input logic [63:0] raw);
        int nb;
        logic [63:0] r;
        logic ok;
        nb = 1 << sz;
        r  = '0;
        ok = (md == 2'd0) || (md == 2'd1 && (sz == 2'd1 || sz == 2'd2)) ||
             (md == 2'd2 && sz != 2'd0);
        if (!v) return 65'd0;
        if (!ok) return {1'b1, 64'd0};
        for (int i = 0; i < nb; i++) begin
            if (md == 2'd2) r[8*i +: 8] = raw[8*(nb-1-i) +: 8];
            else            r[8*i +: 8] = raw[8*i +: 8];
        end
        if (md == 2'd1 && raw[8*nb-1])
            for (int j = 8*nb; j < 64; j++) r[j] = 1'b1;
        return {1'b0, r};
    endfunction

    task automatic apply(input logic v, input logic [1:0] sz, input logic [1:0] md,
                         input logic [63:0] raw);
        @(posedge clk);
        valid_i = v; size_i = sz; mode_i = md; raw_i = raw;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [63:0] exp_d, input logic exp_u);
        total++;
        if (result_o !== exp_d || unsup_o !== exp_u) begin
            bad++;
            $display("FAIL %s: size=%0d mode=%0d got result=%h unsup=%b, expected result=%h unsup=%b",
                     req, size_i, mode_i, result_o, unsup_o, exp_d, exp_u);
        end
    endtask

    task automatic t_idle();
        apply(1'b0, 2'd2, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R7", 64'd0, 1'b0);
        apply(1'b0, 2'd0, 2'd3, 64'h8000_0000_0000_0080);
        check("R7", 64'd0, 1'b0);
    endtask

    task automatic t_zero();
        apply(1'b1, 2'd0, 2'd0, 64'h1122_3344_5566_8899);
        check("R1", 64'h99, 1'b0);
        apply(1'b1, 2'd1, 2'd0, 64'h1122_3344_5566_8899);
        check("R1", 64'h8899, 1'b0);
        apply(1'b1, 2'd2, 2'd0, 64'h1122_3344_5566_8899);
        check("R1", 64'h5566_8899, 1'b0);
        apply(1'b1, 2'd3, 2'd0, 64'h1122_3344_5566_8899);
        check("R1", 64'h1122_3344_5566_8899, 1'b0);
    endtask

    task automatic t_sign();
        apply(1'b1, 2'd1, 2'd1, 64'h1122_3344_5566_8899);
        check("R2", 64'hFFFF_FFFF_FFFF_8899, 1'b0);
        apply(1'b1, 2'd2, 2'd1, 64'h1122_3344_5566_8899);
        check("R2", 64'h5566_8899, 1'b0);
        apply(1'b1, 2'd2, 2'd1, 64'h0000_0000_8000_0001);
        check("R2", 64'hFFFF_FFFF_8000_0001, 1'b0);
        apply(1'b1, 2'd1, 2'd1, 64'hFFFF_FFFF_FFFF_7FFF);
        check("R2", 64'h7FFF, 1'b0);
    endtask

    task automatic t_rev();
        apply(1'b1, 2'd1, 2'd2, 64'h1122_3344_5566_8899);
        check("R3", 64'h9988, 1'b0);
        apply(1'b1, 2'd2, 2'd2, 64'h1122_3344_5566_8899);
        check("R4", 64'h9988_6655, 1'b0);
        apply(1'b1, 2'd3, 2'd2, 64'h1122_3344_5566_8899);
        check("R5", 64'h9988_6655_4433_2211, 1'b0);
    endtask

    task automatic t_unsup();
        apply(1'b1, 2'd0, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R6", 64'd0, 1'b1);
        apply(1'b1, 2'd3, 2'd1, 64'h8000_0000_0000_0000);
        check("R6", 64'd0, 1'b1);
        apply(1'b1, 2'd0, 2'd2, 64'h0123_4567_89AB_CDEF);
        check("R6", 64'd0, 1'b1);
        for (int s = 0; s < 4; s++) begin
            apply(1'b1, 2'(s), 2'd3, 64'h0123_4567_89AB_CDEF);
            check("R6", 64'd0, 1'b1);
        end
    endtask

    task automatic t_sweep();
        logic [63:0] pats [5];
        logic [64:0] e;
        pats[0] = 64'h0123_4567_89AB_CDEF;
        pats[1] = 64'hFEDC_BA98_7654_3210;
        pats[2] = 64'h0000_0000_8000_8080;
        pats[3] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[4] = 64'h0;
        for (int p = 0; p < 5; p++)
            for (int s = 0; s < 4; s++)
                for (int m = 0; m < 4; m++)
                    for (int v = 0; v < 2; v++) begin
                        apply(1'(v), 2'(s), 2'(m), pats[p]);
                        e = model(1'(v), 2'(s), 2'(m), pats[p]);
                        check("R8", e[63:0], e[64]);
                    end
    endtask

    initial begin
        valid_i = 1'b0; size_i = '0; mode_i = '0; raw_i = '0;
        t_idle();
        t_zero();
        t_sign();
        t_rev();
        t_unsup();
        t_sweep();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule